// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Unit

This block holds a joint translation buffer arranged as sets of ways and lets software manage it through four registers: a tag word (page tag, valid flag and an 8-bit address-space ID), a frame word (frame number and permissions, stored without interpretation), an index word and a command word. Writing a command code starts one operation. The operation can be a lookup, a slot choice, a write with or without flushing the downstream micro-TLBs, a read-back, or a plain micro-TLB flush. It completes on the next clock edge.

A lookup that finds nothing, or finds the same key in several ways, reports this in the index word. Duplicate keys are accepted when written and only show up when a lookup matches more than one way. The block drives a one-cycle flush pulse toward the micro-TLBs whenever the command in use calls for one.

Top module: `tlb_cmd_unit`

## Requirements
- R1: After reset the tag, frame and index words read zero, every entry is invalid so any lookup misses, and the flush pulse is low.
- R2: Register address 0 selects the tag word, 1 the frame word, 2 the index word and 3 the command word. In the index word, bit 31 is the error flag and the low IDX_W bits hold the entry number; all other index bits read 0. The command word reads 0. Software writes to addresses 0 to 2 store the written value.
- R3: A command code written to bits 2:0 of address 3 on clock edge k takes effect on edge k+1. The codes are 1 lookup, 2 slot choice, 3 write with flush, 4 write without flush, 5 read and 6 flush only. Codes 0 and 7 change nothing.
- R4: The lookup uses the set selected by tag-word bits PAGE_SHIFT+SET_W-1 down to PAGE_SHIFT. An entry hits when its valid bit (bit 8) is set, its bits 31 down to PAGE_SHIFT equal those of the tag word, and its bits 7:0 (address-space ID) equal those of the tag word. A single hit loads the index word with set*NUM_WAYS+way and clears the error flag.
- R5: A lookup with no hit sets the error flag and zeroes the entry number. An entry with the same page but a different address-space ID does not hit.
- R6: A lookup matching two or more ways sets the error flag and index bit 0.
- R7: The slot-choice command loads the index word with the lowest invalid way of the addressed set and clears the error flag.
- R8: If every way of the set is valid, the slot-choice command returns the way named by that set's round-robin pointer and advances only that set's pointer.
- R9: The write commands store the tag and frame words at the entry named by the index word. Writing both words as zero erases the entry.
- R10: Commands 3 and 6 raise the flush pulse for exactly the one cycle after the edge that executes them. Every other code leaves it low.
- R11: The read command loads the tag and frame words from the entry named by the index word.
- R12: A command's result overrides a software write that lands on the same register at the executing edge. A software write to a different register at that edge still takes effect. The command itself uses the register values held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| utlbInvalidate | output | 1 | One-cycle micro-TLB flush pulse |

## Verification
A command executes one cycle after it is written, so a software register write can arrive on the same edge as the command's own register update. The bench provokes this by holding the write strobe through the execution cycle with a new address and data. It issues a read command while software writes the tag word, and lookups while software writes the index word, the tag word or the frame word. It then checks three things: the command's result wins on a shared register, the software value survives on the other register, and the lookup key is the value held before the concurrent write.

// File: rtl/tlb_cmd_pkg.sv
package tlb_cmd_pkg;
  typedef enum logic [1:0] {
    REG_TAG   = 2'd0,
    REG_FRAME = 2'd1,
    REG_INDEX = 2'd2,
    REG_CMD   = 2'd3
  } regSel_e;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_LOOKUP    = 3'd1,
    CMD_PICK      = 3'd2,
    CMD_WRITE     = 3'd3,
    CMD_WRITE_KEEP = 3'd4,
    CMD_READ      = 3'd5,
    CMD_FLUSH     = 3'd6,
    CMD_RSVD      = 3'd7
  } cmdCode_e;

  typedef struct packed {
    logic lookup;
    logic pick;
    logic write;
    logic read;
    logic flush;
  } cmdStrobe_t;
endpackage

// File: rtl/tlb_cmd_datapath.sv
module tlb_cmd_datapath
  import tlb_cmd_pkg::*;
#(
  parameter int NUM_SETS   = 128,
  parameter int NUM_WAYS   = 2,
  parameter int PAGE_SHIFT = 13,
  parameter int VALID_BIT  = 8,
  parameter int ASID_W     = 8,
  parameter int DATA_W     = 32,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int IDX_W     = SET_W + WAY_W,
  localparam int CNT_W     = WAY_W + 1,
  localparam int ENTRIES   = NUM_SETS * NUM_WAYS
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [DATA_W-1:0] tagIn,
  input  logic [DATA_W-1:0] frameIn,
  input  logic [IDX_W-1:0]  idxIn,
  output logic [CNT_W-1:0]  matchCount,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [IDX_W-1:0]  pickIdx,
  output logic [DATA_W-1:0] rdTag,
  output logic [DATA_W-1:0] rdFrame
);
  logic [DATA_W-1:0] tagMem   [ENTRIES];
  logic [DATA_W-1:0] frameMem [ENTRIES];
  logic [WAY_W-1:0]  rrPtr    [NUM_SETS];

  logic [SET_W-1:0]  lookSet;
  logic [IDX_W-1:0]  wayIdx   [NUM_WAYS];
  logic [NUM_WAYS-1:0] wayMatch;
  logic [NUM_WAYS-1:0] wayValid;
  logic [WAY_W-1:0]  hitWay;
  logic [WAY_W-1:0]  freeWay;
  logic              freeFound;
  logic [WAY_W-1:0]  pickWay;

  assign lookSet = tagIn[PAGE_SHIFT +: SET_W];

  // Ways of one set sit at consecutive entry numbers: {set, way}.
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [DATA_W-1:0] wayTag;
    assign wayIdx[w]   = {lookSet, WAY_W'(w)};
    assign wayTag      = tagMem[wayIdx[w]];
    assign wayValid[w] = wayTag[VALID_BIT];
    assign wayMatch[w] = wayTag[VALID_BIT]
                      && (wayTag[DATA_W-1:PAGE_SHIFT] == tagIn[DATA_W-1:PAGE_SHIFT])
                      && (wayTag[ASID_W-1:0] == tagIn[ASID_W-1:0]);
  end

  always_comb begin
    hitWay    = '0;
    freeWay   = '0;
    freeFound = 1'b0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (wayMatch[w]) hitWay = WAY_W'(w);
      if (!wayValid[w]) begin
        freeFound = 1'b1;
        freeWay   = WAY_W'(w);
      end
    end
  end

  assign matchCount = CNT_W'($countones(wayMatch));
  assign pickWay    = freeFound ? freeWay : rrPtr[lookSet];
  assign hitIdx     = {lookSet, hitWay};
  assign pickIdx    = {lookSet, pickWay};
  assign rdTag      = tagMem[idxIn];
  assign rdFrame    = frameMem[idxIn];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tagMem[e]   <= '0;
        frameMem[e] <= '0;
      end
      for (int s = 0; s < NUM_SETS; s++) rrPtr[s] <= '0;
    end else begin
      if (strobe.write) begin
        tagMem[idxIn]   <= tagIn;
        frameMem[idxIn] <= frameIn;
      end
      if (strobe.pick && !freeFound)
        rrPtr[lookSet] <= rrPtr[lookSet] + WAY_W'(1);
    end
  end
endmodule

// File: rtl/tlb_cmd_ctrl.sv
module tlb_cmd_ctrl
  import tlb_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output cmdStrobe_t        strobe,
  output logic [DATA_W-1:0] tagReg,
  output logic [DATA_W-1:0] frameReg,
  output logic [IDX_W-1:0]  idxVal,
  output logic              idxErr,
  output logic              utlbInvalidate,
  input  logic [CNT_W-1:0]  matchCount,
  input  logic [IDX_W-1:0]  hitIdx,
  input  logic [IDX_W-1:0]  pickIdx,
  input  logic [DATA_W-1:0] rdTag,
  input  logic [DATA_W-1:0] rdFrame
);
  logic     cmdPend;
  cmdCode_e cmdCode;
  logic     swTag, swFrame, swIndex, swCmd;

  assign swTag   = regWrEn && (regAddr == REG_TAG);
  assign swFrame = regWrEn && (regAddr == REG_FRAME);
  assign swIndex = regWrEn && (regAddr == REG_INDEX);
  assign swCmd   = regWrEn && (regAddr == REG_CMD);

  always_comb begin
    strobe = '0;
    if (cmdPend) begin
      case (cmdCode)
        CMD_LOOKUP:     strobe.lookup = 1'b1;
        CMD_PICK:       strobe.pick   = 1'b1;
        CMD_WRITE:      begin strobe.write = 1'b1; strobe.flush = 1'b1; end
        CMD_WRITE_KEEP: strobe.write  = 1'b1;
        CMD_READ:       strobe.read   = 1'b1;
        CMD_FLUSH:      strobe.flush  = 1'b1;
        default:        strobe        = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPend        <= 1'b0;
      cmdCode        <= CMD_NOP;
      tagReg         <= '0;
      frameReg       <= '0;
      idxVal         <= '0;
      idxErr         <= 1'b0;
      utlbInvalidate <= 1'b0;
    end else begin
      cmdPend        <= swCmd;
      if (swCmd) cmdCode <= cmdCode_e'(regWrData[2:0]);
      utlbInvalidate <= strobe.flush;

      if (strobe.read)  tagReg <= rdTag;
      else if (swTag)   tagReg <= regWrData;

      if (strobe.read)  frameReg <= rdFrame;
      else if (swFrame) frameReg <= regWrData;

      if (strobe.lookup) begin
        if (matchCount == '0) begin
          idxErr <= 1'b1;
          idxVal <= '0;
        end else if (matchCount == CNT_W'(1)) begin
          idxErr <= 1'b0;
          idxVal <= hitIdx;
        end else begin
          idxErr <= 1'b1;
          idxVal <= IDX_W'(1);
        end
      end else if (strobe.pick) begin
        idxErr <= 1'b0;
        idxVal <= pickIdx;
      end else if (swIndex) begin
        idxErr <= regWrData[DATA_W-1];
        idxVal <= regWrData[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_TAG:   regRdData = tagReg;
      REG_FRAME: regRdData = frameReg;
      REG_INDEX: regRdData = {idxErr, {(DATA_W-1-IDX_W){1'b0}}, idxVal};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/tlb_cmd_unit.sv
module tlb_cmd_unit
  import tlb_cmd_pkg::*;
#(
  parameter int NUM_SETS   = 128,
  parameter int NUM_WAYS   = 2,
  parameter int PAGE_SHIFT = 13,
  localparam int DATA_W    = 32,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int IDX_W     = SET_W + WAY_W,
  localparam int CNT_W     = WAY_W + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        utlbInvalidate
);
  cmdStrobe_t        strobe;
  logic [DATA_W-1:0] tagReg, frameReg, rdTag, rdFrame;
  logic [IDX_W-1:0]  idxVal, hitIdx, pickIdx;
  logic              idxErr;
  logic [CNT_W-1:0]  matchCount;

  tlb_cmd_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .tagReg(tagReg), .frameReg(frameReg), .idxVal(idxVal), .idxErr(idxErr),
    .utlbInvalidate(utlbInvalidate), .matchCount(matchCount),
    .hitIdx(hitIdx), .pickIdx(pickIdx), .rdTag(rdTag), .rdFrame(rdFrame)
  );

  tlb_cmd_datapath #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS),
                     .PAGE_SHIFT(PAGE_SHIFT), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tagIn(tagReg),
    .frameIn(frameReg), .idxIn(idxVal), .matchCount(matchCount),
    .hitIdx(hitIdx), .pickIdx(pickIdx), .rdTag(rdTag), .rdFrame(rdFrame)
  );
endmodule

// File: rtl/tlb_cmd_checker.sv
module tlb_cmd_checker
  import tlb_cmd_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input cmdStrobe_t       strobe,
  input logic [CNT_W-1:0] matchCount,
  input logic [IDX_W-1:0] idxVal,
  input logic             idxErr,
  input logic             utlbInvalidate
);
  // R3: a decoded command raises at most one operation strobe
  assert_one_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.lookup, strobe.pick, strobe.write, strobe.read}));

  assert_lookup_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && matchCount == '0) |=> (idxErr && idxVal == '0));

  assert_lookup_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && matchCount == CNT_W'(1)) |=> !idxErr);

  assert_lookup_dup_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lookup && matchCount > CNT_W'(1)) |=> (idxErr && idxVal[0]));

  assert_pick_clears_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pick |=> !idxErr);

  assert_flush_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(utlbInvalidate) |-> $past(strobe.flush));
endmodule

bind tlb_cmd_unit tlb_cmd_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .matchCount(matchCount),
  .idxVal(idxVal), .idxErr(idxErr), .utlbInvalidate(utlbInvalidate)
);

// File: tb/tb_tlb_cmd_unit.sv
module tb_tlb_cmd_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        utlbInvalidate;

  int checks = 0;
  int fails  = 0;
  logic lastInv;

  localparam logic [1:0] A_TAG = 2'd0, A_FRAME = 2'd1, A_IDX = 2'd2, A_CMD = 2'd3;
  localparam logic [31:0] ERR = 32'h8000_0000;

  tlb_cmd_unit dut (.clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
                    .regWrData(regWrData), .regRdData(regRdData),
                    .utlbInvalidate(utlbInvalidate));

  always #5 clk = ~clk;

  function automatic logic [31:0] mkTag(int set, int hi, int asid);
    return (32'(hi) << 20) | (32'(set) << 13) | (32'd1 << 8) | 32'(asid);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // Command written at edge k, executes at edge k+1, sampled after k+1.
  task automatic runCmd(logic [2:0] code);
    regWrite(A_CMD, {29'd0, code});
    @(negedge clk);
    lastInv = utlbInvalidate;
  endtask

  // Command plus a software write landing on the executing edge.
  task automatic runCmdWith(logic [2:0] code, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_CMD; regWrData = {29'd0, code};
    @(negedge clk);
    regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    lastInv = utlbInvalidate;
  endtask

  task automatic expectReg(string req, logic [1:0] a, logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    expectReg("R1 tag", A_TAG, 0);
    expectReg("R1 frame", A_FRAME, 0);
    expectReg("R1 index", A_IDX, 0);
    check("R1 flush low", {31'd0, utlbInvalidate}, 0);
    regWrite(A_TAG, mkTag(5, 1, 8'h11));
    runCmd(3'd1);
    expectReg("R1 R5 empty lookup misses", A_IDX, ERR);
  endtask

  task automatic testRegs();
    regWrite(A_IDX, 32'hFFFF_FFFF);
    expectReg("R2 index field mask", A_IDX, 32'h8000_00FF);
    expectReg("R2 command reads zero", A_CMD, 0);
    regWrite(A_FRAME, 32'hDEAD_0001);
    expectReg("R2 frame store", A_FRAME, 32'hDEAD_0001);
  endtask

  task automatic testPickWrite();
    regWrite(A_TAG, mkTag(5, 1, 8'h11));
    runCmd(3'd2);
    expectReg("R7 pick lowest free", A_IDX, 32'd10);
    regWrite(A_FRAME, 32'hAAAA_0001);
    runCmd(3'd3);
    check("R10 write flushes", {31'd0, lastInv}, 1);
    @(negedge clk);
    check("R10 pulse one cycle", {31'd0, utlbInvalidate}, 0);
    runCmd(3'd1);
    expectReg("R4 R9 lookup hit", A_IDX, 32'd10);
    regWrite(A_TAG, mkTag(5, 1, 8'h12));
    runCmd(3'd1);
    expectReg("R5 other asid misses", A_IDX, ERR);
  endtask

  task automatic testKeepAndRead();
    regWrite(A_TAG, mkTag(5, 2, 8'h11));
    runCmd(3'd2);
    expectReg("R7 second free way", A_IDX, 32'd11);
    regWrite(A_FRAME, 32'hBBBB_0002);
    runCmd(3'd4);
    check("R10 keep-write no flush", {31'd0, lastInv}, 0);
    runCmd(3'd1);
    expectReg("R4 hit way1", A_IDX, 32'd11);
    regWrite(A_IDX, 32'd10);
    runCmd(3'd5);
    expectReg("R11 read tag", A_TAG, mkTag(5, 1, 8'h11));
    expectReg("R11 read frame", A_FRAME, 32'hAAAA_0001);
  endtask

  task automatic testRoundRobin();
    regWrite(A_TAG, mkTag(5, 3, 8'h22));
    runCmd(3'd2);
    expectReg("R8 full set first", A_IDX, 32'd10);
    runCmd(3'd2);
    expectReg("R8 full set second", A_IDX, 32'd11);
    runCmd(3'd2);
    expectReg("R8 full set wraps", A_IDX, 32'd10);
    regWrite(A_TAG, mkTag(6, 3, 8'h22));
    runCmd(3'd2);
    expectReg("R8 other set untouched", A_IDX, 32'd12);
  endtask

  task automatic testDupErase();
    regWrite(A_TAG, mkTag(9, 1, 8'h33));
    regWrite(A_FRAME, 32'h1);
    regWrite(A_IDX, 32'd18);
    runCmd(3'd4);
    regWrite(A_IDX, 32'd19);
    runCmd(3'd4);
    runCmd(3'd1);
    expectReg("R6 duplicate", A_IDX, ERR | 32'd1);
    regWrite(A_IDX, 32'd18);
    regWrite(A_TAG, 0);
    regWrite(A_FRAME, 0);
    runCmd(3'd3);
    regWrite(A_TAG, mkTag(9, 1, 8'h33));
    runCmd(3'd1);
    expectReg("R9 erase leaves one", A_IDX, 32'd19);
    regWrite(A_TAG, 0);
    runCmd(3'd3);
    regWrite(A_TAG, mkTag(9, 1, 8'h33));
    runCmd(3'd1);
    expectReg("R9 erased misses", A_IDX, ERR);
    runCmd(3'd2);
    expectReg("R7 R9 erased slot free", A_IDX, 32'd18);
  endtask

  task automatic testFlushNop();
    regWrite(A_IDX, 32'd7);
    runCmd(3'd6);
    check("R10 flush cmd pulse", {31'd0, lastInv}, 1);
    expectReg("R10 flush keeps index", A_IDX, 32'd7);
    runCmd(3'd0);
    check("R3 code0 no pulse", {31'd0, lastInv}, 0);
    runCmd(3'd7);
    check("R3 code7 no pulse", {31'd0, lastInv}, 0);
    expectReg("R3 codes 0/7 keep index", A_IDX, 32'd7);
    expectReg("R3 codes 0/7 keep tag", A_TAG, mkTag(9, 1, 8'h33));
  endtask

  task automatic testConcurrent();
    regWrite(A_IDX, 32'd10);
    runCmdWith(3'd5, A_TAG, 32'h0000_1234);
    expectReg("R12 read beats tag write", A_TAG, mkTag(5, 1, 8'h11));
    regWrite(A_TAG, mkTag(5, 2, 8'h11));
    runCmdWith(3'd1, A_IDX, 32'd5);
    expectReg("R12 lookup beats index write", A_IDX, 32'd11);
    runCmdWith(3'd1, A_FRAME, 32'h77);
    expectReg("R12 frame write kept", A_FRAME, 32'h77);
    regWrite(A_IDX, 32'd3);
    runCmdWith(3'd1, A_TAG, mkTag(5, 1, 8'h11));
    expectReg("R12 lookup uses old tag", A_IDX, 32'd11);
    expectReg("R12 tag write kept", A_TAG, mkTag(5, 1, 8'h11));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testPickWrite();
    testKeepAndRead();
    testRoundRobin();
    testDupErase();
    testFlushNop();
    testConcurrent();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule